// File: doc/BRIEF.md
# Sleep-State Sequencer with Reset Arbitration

This block steps a small microcontroller between a running state and three
sleep levels. The CPU issues one-cycle request strobes to enter a light sleep
(CPU clock gated, everything else running), a deep sleep (main oscillator
stopped) or a deepest sleep (deep sleep with brownout detection and comparators
also switched off). Enabled interrupts end the light sleep. Only interrupts that
are also marked wake-capable end either deep level. A deep-level wake passes
through an oscillator-settle window of programmable length before the CPU clock
returns.

Four reset sources are merged into one system reset: a power-on reset with a
stretch counter, an external pin, a watchdog request and a brownout request.
Any reset puts the sequencer back into the running state. A one-hot cause
register keeps the most recent source. The pin is shared between two roles. A
configuration bit selects either an active-low reset input, which is
synchronised and glitch-filtered, or a plain digital input. During the
power-on stretch the pin always acts as a reset, whatever the bit says.

States (`pwr_state` code): RUN=0, IDLE=1, PD (deep)=2, TPD (deepest)=3, SETTLE=4.
Transitions: RUN→TPD on `tpd_req`; RUN→PD on `pd_req`; RUN→IDLE on `idle_req`;
IDLE→RUN on any `irq_act` bit; PD→SETTLE and TPD→SETTLE on any bit of
`irq_act & irq_wake`; SETTLE→RUN when the settle count is used up; any state→RUN
on `sys_rst`.

Top module: `pwr_seq_top`

## Requirements
- R1: After power-on and the stretch window, with the pin high, `pwr_state`=0 (RUN), `cpu_clk_en`=1, `sys_rst`=0 and `rst_cause`=4'b0001.
- R2: `sys_rst` stays high for POR_STRETCH clock edges after `por_n` rises. During that window the pin acts as an active-low reset whatever `pin_rst_cfg` says, and `pin_data` reads 1.
- R3: In RUN, request strobes sampled in one cycle are served deepest first: `tpd_req` beats `pd_req`, which beats `idle_req`. The new state shows from the next edge.
- R4: IDLE has `cpu_clk_en`=0 and `osc_en`=1. Any set bit of `irq_act` returns the sequencer to RUN at the next edge.
- R5: PD has `cpu_clk_en`=0 and `osc_en`=0, while `bod_en`, `wdt_en` (=`wdt_cfg`), `rtc_en` (=`rtc_cfg`) and `cmp_en` (=`cmp_cfg`) stay on. An interrupt without its `irq_wake` bit set leaves PD and TPD unchanged.
- R6: A wake from PD or TPD enters SETTLE and loads `settle_len`. SETTLE lasts `settle_len`+1 cycles with `cpu_clk_en`=0 and `osc_en`=1, then RUN follows.
- R7: TPD has `bod_en`=0 and `cmp_en`=0. A `bod_rst_req` in TPD causes no reset and leaves the state and cause unchanged.
- R8: In PD and TPD, `rc_osc_en` = `rc_is_sysclk` AND `rtc_cfg`. In every other state, `rc_osc_en` = `rc_is_sysclk`.
- R9: With `pin_rst_cfg`=1, `pin_data` reads 1. A pin low sampled at two consecutive edges raises `sys_rst` three edges after the pin falls, and a one-cycle low pulse causes no reset. With `pin_rst_cfg`=0 (after the stretch), `pin_data` follows the pin two edges late and never resets.
- R10: `sys_rst` returns the state to RUN at the next edge. `rst_cause` records the source with priority power-on > pin > watchdog > brownout, encoded bit0 power-on, bit1 pin, bit2 watchdog, bit3 brownout. A watchdog or brownout request raises `sys_rst` in the same cycle.
- R11: Outside TPD, `cmp_en` equals `cmp_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_i | input | 1 | Shared pin level |
| pin_rst_cfg | input | 1 | 1: pin is reset input; 0: digital input |
| idle_req | input | 1 | Light sleep request strobe |
| pd_req | input | 1 | Deep sleep request strobe |
| tpd_req | input | 1 | Deepest sleep request strobe |
| irq_act | input | N_IRQ | Enabled interrupt requests |
| irq_wake | input | N_IRQ | Wake-capable mask per interrupt |
| settle_len | input | SETTLE_W | Oscillator settle count |
| wdt_rst_req | input | 1 | Watchdog reset request |
| bod_rst_req | input | 1 | Brownout reset request |
| rc_is_sysclk | input | 1 | RC oscillator is the system clock |
| rtc_cfg | input | 1 | Real-time clock enabled |
| cmp_cfg | input | 1 | Comparators enabled by their own control |
| wdt_cfg | input | 1 | Watchdog enabled |
| sys_rst | output | 1 | Merged system reset |
| pwr_state | output | 3 | Current state code |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Main oscillator enable |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| bod_en | output | 1 | Brownout detector enable |
| cmp_en | output | 1 | Comparator enable |
| wdt_en | output | 1 | Watchdog enable |
| rtc_en | output | 1 | Real-time clock enable |
| pin_data | output | 1 | Synchronised pin value as digital input |
| rst_cause | output | 4 | One-hot last reset source |

## Verification
The bench builds the block with N_IRQ=4, SETTLE_W=4 and POR_STRETCH=6. The short stretch makes a second power-on cycle with the pin held low cheap. That run shows the forced reset role, and the moment it hands back to the configuration bit, within a dozen cycles. With a four-bit settle field, both the zero-length settle window and a multi-cycle one can be tried. Four interrupt lines are enough to mix wake-capable and plain requests in the same deep sleep.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PS_RUN    = 3'd0,
        PS_IDLE   = 3'd1,
        PS_PD     = 3'd2,
        PS_TPD    = 3'd3,
        PS_SETTLE = 3'd4
    } pwr_state_e;

    localparam int CAUSE_W = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_POR = 4'b0001;
    localparam logic [CAUSE_W-1:0] CAUSE_PIN = 4'b0010;
    localparam logic [CAUSE_W-1:0] CAUSE_WDT = 4'b0100;
    localparam logic [CAUSE_W-1:0] CAUSE_BOD = 4'b1000;

endpackage

// File: rtl/pwr_seq_rstgen.sv
module pwr_seq_rstgen
    import pwr_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int POR_STRETCH = 16
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               pin_i,
    input  logic               pin_rst_cfg,
    input  logic               wdt_req,
    input  logic               bod_req,
    input  logic               bod_armed,
    output logic               sys_rst,
    output logic               pin_data,
    output logic [CAUSE_W-1:0] cause
);

    localparam int PCW = $clog2(POR_STRETCH + 1);
    localparam logic [PCW-1:0] PCNT_END = PCW'(POR_STRETCH);

    logic [PCW-1:0]       por_cnt;
    logic                 por_busy;
    logic [SYNC_STAGES:0] chain;
    logic                 pin_role_rst;
    logic                 pin_rst;
    logic                 bod_hit;

    // Power-on stretch: reset held until the counter reaches its end value.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            por_cnt <= '0;
        else if (por_cnt != PCNT_END)
            por_cnt <= por_cnt + 1'b1;
    end

    assign por_busy = (por_cnt != PCNT_END);

    // Synchroniser stages plus one filter stage at the top of the chain.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            chain <= '1;
        else
            chain <= {chain[SYNC_STAGES-1:0], pin_i};
    end

    assign pin_role_rst = por_busy | pin_rst_cfg;
    assign pin_rst      = pin_role_rst & ~chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    assign pin_data     = pin_role_rst ? 1'b1 : chain[SYNC_STAGES-1];
    assign bod_hit      = bod_req & bod_armed;
    assign sys_rst      = por_busy | pin_rst | wdt_req | bod_hit;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            cause <= CAUSE_POR;
        else if (por_busy)
            cause <= CAUSE_POR;
        else if (pin_rst)
            cause <= CAUSE_PIN;
        else if (wdt_req)
            cause <= CAUSE_WDT;
        else if (bod_hit)
            cause <= CAUSE_BOD;
    end

    // R10: watchdog without higher-priority source is the recorded cause
    a_r10_wdt_cause: assert property (@(posedge clk) disable iff (!por_n)
        (!por_busy && !pin_rst && wdt_req) |=> (cause == CAUSE_WDT));

    // R9: a pin reset needs the pin low at the previous sampling edge too
    a_r9_pin_two_low: assert property (@(posedge clk) disable iff (!por_n)
        (pin_rst && !por_busy) |-> $past(!chain[SYNC_STAGES-1]));

    // R7: brownout request while disarmed alone never resets
    a_r7_bod_masked: assert property (@(posedge clk) disable iff (!por_n)
        (!bod_armed && bod_req && !por_busy && !pin_rst && !wdt_req) |-> !sys_rst);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int N_IRQ    = 8,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                sys_rst,
    input  logic                idle_req,
    input  logic                pd_req,
    input  logic                tpd_req,
    input  logic [N_IRQ-1:0]    irq_act,
    input  logic [N_IRQ-1:0]    irq_wake,
    input  logic [SETTLE_W-1:0] settle_len,
    output pwr_state_e          state
);

    pwr_state_e          nxt;
    logic [SETTLE_W-1:0] cnt;
    logic [SETTLE_W-1:0] cnt_nxt;
    logic                any_irq;
    logic                any_wake;

    assign any_irq  = |irq_act;
    assign any_wake = |(irq_act & irq_wake);

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (sys_rst) begin
            nxt     = PS_RUN;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                PS_RUN: begin
                    if (tpd_req)
                        nxt = PS_TPD;
                    else if (pd_req)
                        nxt = PS_PD;
                    else if (idle_req)
                        nxt = PS_IDLE;
                end
                PS_IDLE: begin
                    if (any_irq)
                        nxt = PS_RUN;
                end
                PS_PD, PS_TPD: begin
                    if (any_wake) begin
                        nxt     = PS_SETTLE;
                        cnt_nxt = settle_len;
                    end
                end
                PS_SETTLE: begin
                    if (cnt == '0)
                        nxt = PS_RUN;
                    else
                        cnt_nxt = cnt - 1'b1;
                end
                default: nxt = PS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= PS_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // R10: any reset brings the sequencer back to RUN
    a_r10_reset_to_run: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (state == PS_RUN));

    // R3: deepest request wins in RUN
    a_r3_tpd_first: assert property (@(posedge clk) disable iff (!por_n)
        (state == PS_RUN && tpd_req && !sys_rst) |=> (state == PS_TPD));

    // R4: an enabled interrupt ends light sleep
    a_r4_idle_wake: assert property (@(posedge clk) disable iff (!por_n)
        (state == PS_IDLE && any_irq && !sys_rst) |=> (state == PS_RUN));

    // R5: deep levels hold without a wake-capable interrupt
    a_r5_deep_hold: assert property (@(posedge clk) disable iff (!por_n)
        ((state == PS_PD || state == PS_TPD) && !any_wake && !sys_rst)
        |=> (state == $past(state)));

    // R6: an exhausted settle count releases the CPU
    a_r6_settle_exit: assert property (@(posedge clk) disable iff (!por_n)
        (state == PS_SETTLE && cnt == '0 && !sys_rst) |=> (state == PS_RUN));

endmodule

// File: rtl/pwr_seq_dec.sv
module pwr_seq_dec
    import pwr_seq_pkg::*;
(
    input  pwr_state_e state,
    input  logic       rc_is_sysclk,
    input  logic       rtc_cfg,
    input  logic       cmp_cfg,
    input  logic       wdt_cfg,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       rc_osc_en,
    output logic       bod_en,
    output logic       cmp_en,
    output logic       wdt_en,
    output logic       rtc_en
);

    always_comb begin
        cpu_clk_en = 1'b0;
        osc_en     = 1'b1;
        rc_osc_en  = rc_is_sysclk;
        bod_en     = 1'b1;
        cmp_en     = cmp_cfg;
        wdt_en     = wdt_cfg;
        rtc_en     = rtc_cfg;
        unique case (state)
            PS_RUN: cpu_clk_en = 1'b1;
            PS_IDLE, PS_SETTLE: begin
            end
            PS_PD: begin
                osc_en    = 1'b0;
                rc_osc_en = rc_is_sysclk & rtc_cfg;
            end
            PS_TPD: begin
                osc_en    = 1'b0;
                rc_osc_en = rc_is_sysclk & rtc_cfg;
                bod_en    = 1'b0;
                cmp_en    = 1'b0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int N_IRQ       = 8,
    parameter int SETTLE_W    = 8,
    parameter int POR_STRETCH = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                pin_i,
    input  logic                pin_rst_cfg,
    input  logic                idle_req,
    input  logic                pd_req,
    input  logic                tpd_req,
    input  logic [N_IRQ-1:0]    irq_act,
    input  logic [N_IRQ-1:0]    irq_wake,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                wdt_rst_req,
    input  logic                bod_rst_req,
    input  logic                rc_is_sysclk,
    input  logic                rtc_cfg,
    input  logic                cmp_cfg,
    input  logic                wdt_cfg,
    output logic                sys_rst,
    output logic [2:0]          pwr_state,
    output logic                cpu_clk_en,
    output logic                osc_en,
    output logic                rc_osc_en,
    output logic                bod_en,
    output logic                cmp_en,
    output logic                wdt_en,
    output logic                rtc_en,
    output logic                pin_data,
    output logic [3:0]          rst_cause
);

    pwr_state_e st;

    pwr_seq_rstgen #(
        .SYNC_STAGES (SYNC_STAGES),
        .POR_STRETCH (POR_STRETCH)
    ) rstgen_i (
        .clk         (clk),
        .por_n       (por_n),
        .pin_i       (pin_i),
        .pin_rst_cfg (pin_rst_cfg),
        .wdt_req     (wdt_rst_req),
        .bod_req     (bod_rst_req),
        .bod_armed   (bod_en),
        .sys_rst     (sys_rst),
        .pin_data    (pin_data),
        .cause       (rst_cause)
    );

    pwr_seq_fsm #(
        .N_IRQ    (N_IRQ),
        .SETTLE_W (SETTLE_W)
    ) fsm_i (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst    (sys_rst),
        .idle_req   (idle_req),
        .pd_req     (pd_req),
        .tpd_req    (tpd_req),
        .irq_act    (irq_act),
        .irq_wake   (irq_wake),
        .settle_len (settle_len),
        .state      (st)
    );

    pwr_seq_dec dec_i (
        .state        (st),
        .rc_is_sysclk (rc_is_sysclk),
        .rtc_cfg      (rtc_cfg),
        .cmp_cfg      (cmp_cfg),
        .wdt_cfg      (wdt_cfg),
        .cpu_clk_en   (cpu_clk_en),
        .osc_en       (osc_en),
        .rc_osc_en    (rc_osc_en),
        .bod_en       (bod_en),
        .cmp_en       (cmp_en),
        .wdt_en       (wdt_en),
        .rtc_en       (rtc_en)
    );

    assign pwr_state = st;

endmodule

// File: tb/pwr_seq_top_tb_top.sv
module pwr_seq_top_tb_top;

    localparam int NI = 4;
    localparam int SW = 4;
    localparam int PS = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          por_n = 1'b0, pin_i = 1'b1, pin_rst_cfg = 1'b0;
    logic          idle_req = 1'b0, pd_req = 1'b0, tpd_req = 1'b0;
    logic [NI-1:0] irq_act = '0, irq_wake = '0;
    logic [SW-1:0] settle_len = '0;
    logic          wdt_rst_req = 1'b0, bod_rst_req = 1'b0;
    logic          rc_is_sysclk = 1'b0, rtc_cfg = 1'b0, cmp_cfg = 1'b1, wdt_cfg = 1'b1;

    logic       sys_rst, cpu_clk_en, osc_en, rc_osc_en, bod_en, cmp_en, wdt_en, rtc_en, pin_data;
    logic [2:0] pwr_state;
    logic [3:0] rst_cause;

    pwr_seq_top #(.N_IRQ(NI), .SETTLE_W(SW), .POR_STRETCH(PS), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .por_n(por_n), .pin_i(pin_i), .pin_rst_cfg(pin_rst_cfg),
        .idle_req(idle_req), .pd_req(pd_req), .tpd_req(tpd_req),
        .irq_act(irq_act), .irq_wake(irq_wake), .settle_len(settle_len),
        .wdt_rst_req(wdt_rst_req), .bod_rst_req(bod_rst_req),
        .rc_is_sysclk(rc_is_sysclk), .rtc_cfg(rtc_cfg), .cmp_cfg(cmp_cfg), .wdt_cfg(wdt_cfg),
        .sys_rst(sys_rst), .pwr_state(pwr_state), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
        .rc_osc_en(rc_osc_en), .bod_en(bod_en), .cmp_en(cmp_en), .wdt_en(wdt_en),
        .rtc_en(rtc_en), .pin_data(pin_data), .rst_cause(rst_cause)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: pin history, stretch count, state code, settle count, cause
    int         m_por;
    bit         m_h1, m_h2, m_h3;
    int         m_st;
    int         m_cnt;
    logic [3:0] m_cause;

    function automatic bit m_busy();
        return m_por < PS;
    endfunction
    function automatic bit m_role();
        return m_busy() || pin_rst_cfg;
    endfunction
    function automatic bit m_pin_rst();
        return m_role() && !m_h2 && !m_h3;
    endfunction
    function automatic bit m_bod();
        return bod_rst_req && (m_st != 3);
    endfunction
    function automatic bit m_rst();
        return m_busy() || m_pin_rst() || wdt_rst_req || m_bod();
    endfunction

    always @(posedge clk or negedge por_n) begin : model
        int nst;
        int ncnt;
        logic [3:0] nc;
        if (!por_n) begin
            m_por = 0; m_h1 = 1; m_h2 = 1; m_h3 = 1;
            m_st = 0; m_cnt = 0; m_cause = 4'b0001;
        end else begin
            nst = m_st; ncnt = m_cnt; nc = m_cause;
            if (m_busy()) nc = 4'b0001;
            else if (m_pin_rst()) nc = 4'b0010;
            else if (wdt_rst_req) nc = 4'b0100;
            else if (m_bod()) nc = 4'b1000;
            if (m_rst()) begin
                nst = 0;
            end else begin
                case (m_st)
                    0: if (tpd_req) nst = 3; else if (pd_req) nst = 2; else if (idle_req) nst = 1;
                    1: if (irq_act != 0) nst = 0;
                    2, 3: if ((irq_act & irq_wake) != 0) begin nst = 4; ncnt = settle_len; end
                    default: if (m_cnt == 0) nst = 0; else ncnt = m_cnt - 1;
                endcase
            end
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = pin_i;
            if (m_por < PS) m_por++;
            m_st = nst; m_cnt = ncnt; m_cause = nc;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R3 pwr_state", pwr_state, m_st);
            chk("R4 cpu_clk_en", cpu_clk_en, m_st == 0);
            chk("R5 osc_en", osc_en, m_st == 0 || m_st == 1 || m_st == 4);
            chk("R8 rc_osc_en", rc_osc_en,
                (m_st == 2 || m_st == 3) ? (rc_is_sysclk && rtc_cfg) : rc_is_sysclk);
            chk("R7 bod_en", bod_en, m_st != 3);
            chk("R11 cmp_en", cmp_en, cmp_cfg && m_st != 3);
            chk("R5 wdt_en", wdt_en, wdt_cfg);
            chk("R5 rtc_en", rtc_en, rtc_cfg);
            chk("R10 sys_rst", sys_rst, m_rst());
            chk("R10 rst_cause", rst_cause, m_cause);
            chk("R9 pin_data", pin_data, m_role() ? 1 : m_h2);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic look();
        #3;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        tick(2);
        por_n = 1'b1;
        tick(PS + 1); look();
        chk("R1 state", pwr_state, 0);
        chk("R1 cause", rst_cause, 1);
        chk("R1 sys_rst", sys_rst, 0);
        chk("R1 cpu_clk_en", cpu_clk_en, 1);

        idle_req = 1'b1; tick(1); idle_req = 1'b0; look();
        chk("R3 idle entry", pwr_state, 1);
        chk("R4 idle cpu off", cpu_clk_en, 0);
        chk("R4 idle osc on", osc_en, 1);
        irq_act = 4'b0100; tick(1); irq_act = '0; look();
        chk("R4 idle wake", pwr_state, 0);

        rc_is_sysclk = 1'b1; rtc_cfg = 1'b1;
        pd_req = 1'b1; tick(1); pd_req = 1'b0; look();
        chk("R5 pd state", pwr_state, 2);
        chk("R5 pd osc off", osc_en, 0);
        chk("R5 pd bod on", bod_en, 1);
        chk("R8 rc kept", rc_osc_en, 1);
        rtc_cfg = 1'b0; look();
        chk("R8 rc dropped", rc_osc_en, 0);
        irq_wake = 4'b0010; irq_act = 4'b0001; tick(2); irq_act = '0; look();
        chk("R5 non-wake ignored", pwr_state, 2);

        settle_len = 4'd3; irq_act = 4'b0010; tick(1); irq_act = '0; look();
        chk("R6 settle entry", pwr_state, 4);
        chk("R6 settle cpu off", cpu_clk_en, 0);
        tick(3); look();
        chk("R6 settle last cycle", pwr_state, 4);
        tick(1); look();
        chk("R6 settle exit", pwr_state, 0);

        idle_req = 1'b1; pd_req = 1'b1; tpd_req = 1'b1; tick(1);
        idle_req = 1'b0; pd_req = 1'b0; tpd_req = 1'b0; look();
        chk("R3 deepest wins", pwr_state, 3);
        chk("R7 tpd bod off", bod_en, 0);
        chk("R7 tpd cmp off", cmp_en, 0);
        bod_rst_req = 1'b1; look();
        chk("R7 bod ignored", sys_rst, 0);
        tick(1); bod_rst_req = 1'b0; look();
        chk("R7 tpd kept", pwr_state, 3);
        chk("R7 cause kept", rst_cause, 1);

        settle_len = 4'd0; irq_act = 4'b0010; tick(1); irq_act = '0; look();
        chk("R6 zero settle", pwr_state, 4);
        tick(1); look();
        chk("R6 zero settle exit", pwr_state, 0);

        bod_rst_req = 1'b1; look();
        chk("R10 bod reset", sys_rst, 1);
        tick(1); bod_rst_req = 1'b0; look();
        chk("R10 bod cause", rst_cause, 8);

        pd_req = 1'b1; tick(1); pd_req = 1'b0;
        wdt_rst_req = 1'b1; bod_rst_req = 1'b1; look();
        chk("R10 wdt reset", sys_rst, 1);
        tick(1); wdt_rst_req = 1'b0; bod_rst_req = 1'b0; look();
        chk("R10 wdt to run", pwr_state, 0);
        chk("R10 wdt over bod", rst_cause, 4);

        pin_rst_cfg = 1'b1; look();
        chk("R9 reset role reads 1", pin_data, 1);
        pin_i = 1'b0; tick(1); pin_i = 1'b1; tick(3); look();
        chk("R9 glitch no reset", sys_rst, 0);
        chk("R9 glitch cause", rst_cause, 4);
        idle_req = 1'b1; tick(1); idle_req = 1'b0;
        pin_i = 1'b0; tick(2); look();
        chk("R9 not yet", sys_rst, 0);
        tick(1); look();
        chk("R9 pin reset", sys_rst, 1);
        chk("R9 still idle", pwr_state, 1);
        tick(1); look();
        chk("R9 back to run", pwr_state, 0);
        chk("R9 pin cause", rst_cause, 2);
        pin_i = 1'b1; tick(3); look();
        chk("R9 released", sys_rst, 0);

        pin_rst_cfg = 1'b0; pin_i = 1'b0; tick(1); look();
        chk("R9 data lag", pin_data, 1);
        tick(1); look();
        chk("R9 data follows", pin_data, 0);
        chk("R9 no reset as input", sys_rst, 0);
        pin_i = 1'b1; tick(2); look();
        chk("R9 data high", pin_data, 1);

        cmp_cfg = 1'b0; look();
        chk("R11 cmp off", cmp_en, 0);
        cmp_cfg = 1'b1; look();
        chk("R11 cmp on", cmp_en, 1);

        por_n = 1'b0; pin_i = 1'b0; look();
        chk("R2 por state", pwr_state, 0);
        chk("R2 por cause", rst_cause, 1);
        chk("R2 por reset", sys_rst, 1);
        tick(2); por_n = 1'b1; tick(3); look();
        chk("R2 stretch reset", sys_rst, 1);
        chk("R2 forced role", pin_data, 1);
        tick(4); look();
        chk("R2 stretch over", sys_rst, 0);
        chk("R2 role handed back", pin_data, 0);
        chk("R2 cause por", rst_cause, 1);
        pin_i = 1'b1; tick(3);

        finish_run();
    end

endmodule